// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the read-after-write hazard controller for an in-order integer pipeline of five stages: fetch, decode, execute, memory and writeback. Every instruction passes through all five stages. Operands are read in decode and results are written in writeback. Because all writes land in one stage and every read comes before it, only read-after-write dependences can occur. The block therefore looks for no other kind of hazard.

The block is purely combinational. It compares the source register numbers of the execute-stage instruction with the destinations of the older instructions in the memory and writeback stages. From that it drives the select code of each execute-stage operand multiplexer. It also compares the decode-stage sources with the destination of a load sitting in execute. On a match it freezes the program counter and the fetch/decode register, and it turns the decode/execute register into a no-operation bubble for one cycle. Once that bubble has opened a gap, the loaded value reaches its consumer over the bypass from the writeback stage. Register 0 always reads as zero, so it never takes part in a bypass or an interlock. The register file writes early in the cycle and reads late in the cycle, so a writeback-stage producer needs no path into decode.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An execute-stage operand selects code 2'b10 (result held in the memory stage) when the memory-stage instruction writes (mem_wen=1), its destination equals the operand's source, and that source is not register 0.
- R2: An operand selects code 2'b01 (result held in the writeback stage) when the writeback-stage instruction writes a nonzero destination equal to the source and the memory stage does not match per R1.
- R3: When both the memory and the writeback stage match a source, the younger memory-stage result wins (code 2'b10).
- R4: In every other case the operand selects code 2'b00 (register file value). A source of register 0 always yields 2'b00. Code 2'b11 is never produced.
- R5: hold_front is 1 exactly when the execute-stage instruction is a load (exe_load=1, exe_wen=1) with a nonzero destination equal to a decode source whose use flag is 1.
- R6: No stall occurs when the matching decode source is unused, when the execute-stage producer is not a load, when its destination is register 0, or when only the memory or writeback stages match.
- R7: insert_bubble equals hold_front in every cycle, so exactly one bubble enters execute per stall cycle.
- R8: In a load followed directly by a consumer, the stall lasts one cycle. With the load then in memory and a bubble in execute there is no stall, and with the load in writeback and the consumer in execute the operand selects 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register of the decode-stage instruction |
| dec_src_b | input | REG_W | Second source register of the decode-stage instruction |
| dec_use_a | input | 1 | Decode instruction really reads its first source |
| dec_use_b | input | 1 | Decode instruction really reads its second source |
| exe_src_a | input | REG_W | First source register of the execute-stage instruction |
| exe_src_b | input | REG_W | Second source register of the execute-stage instruction |
| exe_dst | input | REG_W | Destination of the execute-stage instruction |
| exe_wen | input | 1 | Execute-stage instruction writes a register |
| exe_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_W | Destination of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| opa_sel | output | 2 | Select code for the first execute operand multiplexer |
| opb_sel | output | 2 | Select code for the second execute operand multiplexer |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| insert_bubble | output | 1 | Load a no-operation into the decode/execute register |

## Verification
Every output is a combinational function of the stage registers that drive it. Each result is due in the same cycle as its stimulus, with no register between input and output. The bench applies each vector on the falling clock edge and samples a quarter period later, so no result depends on the ordering at the rising edge. The load-use sequence for R8 is stepped one clock per pipeline advance. Each step is checked in the cycle that the stage contents describe.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      OPS_FILE = 2'b00,
      OPS_WB   = 2'b01,
      OPS_MEM  = 2'b10
   } ops_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);
   logic nz;

   generate
      if (ZERO_HARD) begin : g_zero_reg
         assign nz = |src;
      end else begin : g_no_zero_reg
         assign nz = 1'b1;
      end
   endgenerate

   assign hit = wen & nz & (src == dst);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wen,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wen,
   output ops_sel_e         sel
);
   logic mem_hit;
   logic wb_hit;

   fwd_match #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_mem_cmp (
      .src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit)
   );
   fwd_match #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_wb_cmp (
      .src(src), .dst(wb_dst), .wen(wb_wen), .hit(wb_hit)
   );

   always_comb begin
      if (mem_hit)     sel = OPS_MEM;
      else if (wb_hit) sel = OPS_WB;
      else             sel = OPS_FILE;
   end

   always_comb begin
      // R4
      idle_stages_chk: assert (mem_wen || wb_wen || sel == OPS_FILE)
         else $error("operand bypassed with no writing producer");
   end
endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
   parameter int REG_W     = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
   input  logic [NUM_SRC-1:0]            dec_use,
   input  logic [REG_W-1:0]              exe_dst,
   input  logic                          exe_wen,
   input  logic                          exe_load,
   output logic                          stall
);
   logic [NUM_SRC-1:0] hit;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      fwd_match #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_cmp (
         .src(dec_src[i]), .dst(exe_dst), .wen(exe_wen), .hit(hit[i])
      );
   end

   assign stall = exe_load & |(hit & dec_use);

   always_comb begin
      // R6
      unused_src_chk: assert (|dec_use || !stall)
         else $error("stall raised with no source in use");
   end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   input  logic             dec_use_a,
   input  logic             dec_use_b,
   input  logic [REG_W-1:0] exe_src_a,
   input  logic [REG_W-1:0] exe_src_b,
   input  logic [REG_W-1:0] exe_dst,
   input  logic             exe_wen,
   input  logic             exe_load,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wen,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wen,
   output logic [1:0]       opa_sel,
   output logic [1:0]       opb_sel,
   output logic             hold_front,
   output logic             insert_bubble
);
   localparam int NUM_SRC = 2;

   initial begin
      reg_w_range_chk: assert (REG_W >= 2 && REG_W <= 8)
         else $error("REG_W out of supported range");
   end

   logic [NUM_SRC-1:0][REG_W-1:0] exe_src;
   logic [NUM_SRC-1:0][REG_W-1:0] dec_src;
   ops_sel_e [NUM_SRC-1:0]        sel;
   logic                          stall;

   assign exe_src = {exe_src_b, exe_src_a};
   assign dec_src = {dec_src_b, dec_src_a};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
      fwd_operand_sel #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_sel (
         .src(exe_src[i]), .mem_dst(mem_dst), .mem_wen(mem_wen),
         .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(sel[i])
      );
   end

   fwd_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .ZERO_HARD(ZERO_HARD)) u_lu (
      .dec_src(dec_src), .dec_use({dec_use_b, dec_use_a}),
      .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_load(exe_load),
      .stall(stall)
   );

   assign opa_sel       = sel[0];
   assign opb_sel       = sel[1];
   assign hold_front    = stall;
   assign insert_bubble = stall;

   always_comb begin
      // R5
      stall_needs_load_chk: assert (!hold_front || (exe_load && exe_wen))
         else $error("stall without a writing load in execute");
      // R4
      legal_code_chk: assert (opa_sel != 2'b11 && opb_sel != 2'b11)
         else $error("illegal operand select code");
      // R4
      zero_src_fwd_chk: assert (!ZERO_HARD || exe_src_a != '0 || opa_sel == 2'b00)
         else $error("register 0 bypassed");
      // R6
      zero_dst_stall_chk: assert (!ZERO_HARD || exe_dst != '0 || !hold_front)
         else $error("stall on register 0 destination");
   end
endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
   localparam int CLK_P = 10;
   localparam int RW    = 3;
   localparam int NR    = 1 << RW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [RW-1:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst;
   logic dec_use_a, dec_use_b, exe_wen, exe_load, mem_wen, wb_wen;
   logic [1:0] opa_sel, opb_sel;
   logic hold_front, insert_bubble;

   int tests = 0;
   int fails = 0;

   fwd_hazard_unit #(.REG_W(RW), .ZERO_HARD(1'b1)) uut (
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
      .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
      .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_load(exe_load),
      .mem_dst(mem_dst), .mem_wen(mem_wen),
      .wb_dst(wb_dst), .wb_wen(wb_wen),
      .opa_sel(opa_sel), .opb_sel(opb_sel),
      .hold_front(hold_front), .insert_bubble(insert_bubble)
   );

   function automatic logic [1:0] exp_sel(int s, int md, int mw, int wd, int ww);
      if (s != 0 && mw != 0 && md == s) return 2'b10;
      if (s != 0 && ww != 0 && wd == s) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      dec_src_a = '0; dec_src_b = '0; dec_use_a = 0; dec_use_b = 0;
      exe_src_a = '0; exe_src_b = '0; exe_dst = '0; exe_wen = 0; exe_load = 0;
      mem_dst = '0; mem_wen = 0; wb_dst = '0; wb_wen = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8 actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      clear_all();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #(CLK_P/4);
      // reset state: idle pipeline
      check("R4 idle opa", opa_sel, 0);
      check("R4 idle opb", opb_sel, 0);
      check("R6 idle stall", hold_front, 0);
      check("R7 idle bubble", insert_bubble, 0);

      // forwarding sweep: R1 R2 R3 R4, with R6 for the quiet interlock
      for (int s = 0; s < NR; s++)
         for (int md = 0; md < NR; md++)
            for (int wd = 0; wd < NR; wd++)
               for (int w = 0; w < 4; w++) begin
                  @(negedge clk);
                  clear_all();
                  exe_src_a = RW'(s); exe_src_b = RW'(NR - 1 - s);
                  mem_dst = RW'(md); wb_dst = RW'(wd);
                  mem_wen = w[0]; wb_wen = w[1];
                  dec_src_a = RW'(md); dec_use_a = 1;
                  #(CLK_P/4);
                  begin
                     logic [1:0] ea, eb;
                     ea = exp_sel(s, md, w & 1, wd, w >> 1);
                     eb = exp_sel(NR - 1 - s, md, w & 1, wd, w >> 1);
                     if (s != 0 && w[0] && w[1] && md == s && wd == s)
                        check("R3 younger wins opa", opa_sel, ea);
                     else if (ea == 2'b10) check("R1 mem bypass opa", opa_sel, ea);
                     else if (ea == 2'b01) check("R2 wb bypass opa", opa_sel, ea);
                     else check("R4 file opa", opa_sel, ea);
                     check("R1 R2 R4 opb", opb_sel, eb);
                     check("R6 no load no stall", hold_front, 0);
                  end
               end

      // interlock sweep: R5 R6 R7
      for (int sa = 0; sa < NR; sa++)
         for (int sb = 0; sb < NR; sb++)
            for (int d = 0; d < NR; d++)
               for (int f = 0; f < 16; f++) begin
                  @(negedge clk);
                  clear_all();
                  dec_src_a = RW'(sa); dec_src_b = RW'(sb); exe_dst = RW'(d);
                  dec_use_a = f[0]; dec_use_b = f[1]; exe_load = f[2]; exe_wen = f[3];
                  mem_dst = RW'(sa); mem_wen = 1; wb_dst = RW'(sb); wb_wen = 1;
                  #(CLK_P/4);
                  begin
                     int e;
                     e = (f[2] && f[3] && d != 0 &&
                          ((f[0] && d == sa) || (f[1] && d == sb))) ? 1 : 0;
                     if (e == 1) check("R5 load-use stall", hold_front, e);
                     else check("R6 no stall", hold_front, e);
                     check("R7 bubble with stall", insert_bubble, e);
                  end
               end

      // R8: load r3, then consumer of r3 on source b
      @(negedge clk);
      clear_all();
      exe_dst = 3'd3; exe_wen = 1; exe_load = 1;
      dec_src_b = 3'd3; dec_use_b = 1;
      #(CLK_P/4);
      check("R8 step1 stall", hold_front, 1);
      check("R8 step1 bubble", insert_bubble, 1);
      @(negedge clk);
      clear_all();
      mem_dst = 3'd3; mem_wen = 1;
      dec_src_b = 3'd3; dec_use_b = 1;
      #(CLK_P/4);
      check("R8 step2 no stall", hold_front, 0);
      check("R8 step2 no bubble", insert_bubble, 0);
      @(negedge clk);
      clear_all();
      wb_dst = 3'd3; wb_wen = 1;
      exe_src_b = 3'd3;
      #(CLK_P/4);
      check("R8 step3 wb bypass", opb_sel, 2'b01);
      check("R8 step3 no stall", hold_front, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule